// File: doc/BRIEF.md
# Slot Power Status and Fault Register

This block keeps the per-slot power status of a hot-swap controller. Five supply rails (3.3 V, 5 V, +12 V, -12 V and an auxiliary rail) each report overcurrent events as single-cycle pulses. The block latches every event into a sticky status bit. It also reports the live state of the main and auxiliary power paths, and it drives an active-low interrupt and an active-low fault output.

Software reaches the register through a small parallel port with a command address, a write strobe with data, and a read strobe with registered read data. Status bits are cleared by writing a one to them. The fault output follows separate rules. It is latched on its own and is released only by the enable input of the rail group that tripped: ON for the four main rails, AUXEN for the auxiliary rail. When the power paths are under management-interface control, the fault output never asserts.

Top module: `slot_pwr_status`

## Requirements
- R1: After reset, a read of the register returns 00h, fault_n is 1 and int_n is 1.
- R2: The register answers only to command address 05h. A read strobe loads rd_data on the next clock edge: the register contents on a hit, 00h on any other address or when no read is strobed. Writes to other addresses change nothing.
- R3: An overcurrent pulse on oc_evt[i] sets status bit i, and the bit stays set. The mapping is D4 auxiliary, D3 -12 V, D2 +12 V, D1 5 V, D0 3.3 V.
- R4: Writing 1 to any of D4..D0 at address 05h clears that bit. Writing 0 leaves the bit unchanged. Writes to D7..D5 have no effect.
- R5: If an overcurrent pulse arrives in the same cycle as a write that clears the same bit, the bit stays 1.
- R6: int_n is 0 exactly when at least one of D4..D0 is set.
- R7: D6 reads main_good and D5 reads aux_good as they are at the read strobe.
- R8: An event on any main rail (oc_evt[3:0]) drives fault_n low on the next edge. fault_n then stays low until on_en is sampled low. Clearing status bits does not release it.
- R9: An auxiliary event (oc_evt[4]) holds fault_n low until auxen_en is sampled low. Lowering on_en alone does not release it.
- R10: After both kinds of event, fault_n is released only once on_en and auxen_en have each been sampled low at some point since their event.
- R11: While mgmt_mode is 1, events still set status bits, but fault_n stays 1. Setting mgmt_mode releases a held fault on the next edge.
- R12: D7 reads 1 exactly when fault_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | 8 | Command address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data (1 clears the matching status bit) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| oc_evt | input | 5 | Per-rail overcurrent event pulses |
| main_good | input | 1 | Main power paths are on |
| aux_good | input | 1 | Auxiliary power path is on |
| on_en | input | 1 | Main power enable input |
| auxen_en | input | 1 | Auxiliary power enable input |
| mgmt_mode | input | 1 | Power paths under management-interface control |
| fault_n | output | 1 | Active-low latched fault output |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: five rails, an 8-bit command address and command code 05h. With these values every bit of the register and its field order can be seen from the bench. The scenarios run each fault release order: main only, auxiliary only, both groups with the enables lowered at different times, and the management-mode override both before and during a held fault. They also cover a set and a clear that hit the same bit in the same cycle.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    // Fault holder state: one arm per rail group
    typedef struct packed {
        logic main_arm;
        logic aux_arm;
    } hold_t;

    // Reduce the main-rail part of an event vector (all but the top rail)
    function automatic logic any_main(input logic [31:0] evt, input int unsigned rails);
        logic r;
        r = 1'b0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i + 1 < rails) r = r | evt[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/spw_oc_bank.sv
module spw_oc_bank #(
    parameter int unsigned RAIL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAIL_W-1:0] evt,
    input  logic [RAIL_W-1:0] clr,
    output logic [RAIL_W-1:0] flags
);

    typedef struct packed {
        logic [RAIL_W-1:0] flag;
    } bank_t;

    bank_t             bank_d, bank_q;
    logic [RAIL_W-1:0] nxt;

    // Per rail: a new event wins over a clear in the same cycle
    for (genvar i = 0; i < RAIL_W; i++) begin : g_rail
        assign nxt[i] = evt[i] | (bank_q.flag[i] & ~clr[i]);
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.flag = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flags = bank_q.flag;

endmodule

// File: rtl/spw_fault_hold.sv
module spw_fault_hold
    import slot_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_main,
    input  logic evt_aux,
    input  logic on_en,
    input  logic auxen_en,
    input  logic mgmt_mode,
    output logic fault_n
);

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (mgmt_mode) begin
            hold_d.main_arm = 1'b0;
            hold_d.aux_arm  = 1'b0;
        end else begin
            // each arm drops only with its own enable; new events win
            hold_d.main_arm = evt_main | (hold_q.main_arm & on_en);
            hold_d.aux_arm  = evt_aux  | (hold_q.aux_arm  & auxen_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign fault_n = ~(hold_q.main_arm | hold_q.aux_arm);

endmodule

// File: rtl/spw_reg_port.sv
module spw_reg_port #(
    parameter int unsigned          ADDR_W   = 8,
    parameter int unsigned          DATA_W   = 8,
    parameter int unsigned          RW_W     = 5,
    parameter logic [ADDR_W-1:0]    CMD_CODE = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] status,
    output logic [RW_W-1:0]   clr,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t port_d, port_q;
    logic  hit;
    logic  unused_hi;

    assign hit       = (cmd_addr == CMD_CODE);
    assign clr       = (wr_en && hit) ? wr_data[RW_W-1:0] : '0;
    assign unused_hi = ^wr_data[DATA_W-1:RW_W];

    always_comb begin
        port_d       = port_q;
        port_d.rdata = (rd_en && hit) ? status : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign rd_data = port_q.rdata;

endmodule

// File: rtl/slot_pwr_status.sv
module slot_pwr_status
    import slot_pwr_pkg::*;
#(
    parameter int unsigned       RAIL_W   = 5,
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_CODE = 8'h05
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic                 wr_en,
    input  logic [RAIL_W+2:0]    wr_data,
    input  logic                 rd_en,
    output logic [RAIL_W+2:0]    rd_data,
    input  logic [RAIL_W-1:0]    oc_evt,
    input  logic                 main_good,
    input  logic                 aux_good,
    input  logic                 on_en,
    input  logic                 auxen_en,
    input  logic                 mgmt_mode,
    output logic                 fault_n,
    output logic                 int_n
);

    localparam int unsigned DATA_W = RAIL_W + 3;

    logic [RAIL_W-1:0] flags;
    logic [RAIL_W-1:0] clr;
    logic [DATA_W-1:0] status;
    logic              evt_main;
    logic              evt_aux;

    assign evt_main = any_main(32'(oc_evt), RAIL_W);
    assign evt_aux  = oc_evt[RAIL_W-1];

    spw_oc_bank #(.RAIL_W(RAIL_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (oc_evt),
        .clr   (clr),
        .flags (flags)
    );

    spw_fault_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_main  (evt_main),
        .evt_aux   (evt_aux),
        .on_en     (on_en),
        .auxen_en  (auxen_en),
        .mgmt_mode (mgmt_mode),
        .fault_n   (fault_n)
    );

    // Fault summary on top, then live path states, then sticky rail flags
    assign status = {~fault_n, main_good, aux_good, flags};
    assign int_n  = ~(|flags);

    spw_reg_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RW_W     (RAIL_W),
        .CMD_CODE (CMD_CODE)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_addr (cmd_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .status   (status),
        .clr      (clr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/slot_pwr_status_chk.sv
module slot_pwr_status_chk #(
    parameter int unsigned RAIL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [RAIL_W+2:0] rd_data,
    input logic [RAIL_W-1:0] oc_evt,
    input logic              on_en,
    input logic              auxen_en,
    input logic              mgmt_mode,
    input logic              fault_n,
    input logic              int_n
);

    // R2: no read strobe, zero read data next cycle
    p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R3 / R6: any event raises the interrupt
    p_evt_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_evt) |=> !int_n);

    // R4: without a write the interrupt cannot release
    p_int_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !wr_en) |=> !int_n);

    // R8: main-rail event asserts the fault
    p_main_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|oc_evt[RAIL_W-2:0]) && !mgmt_mode) |=> !fault_n);

    // R9: aux event asserts the fault
    p_aux_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_evt[RAIL_W-1] && !mgmt_mode) |=> !fault_n);

    // R10: with both enables high a held fault stays held
    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && on_en && auxen_en && !mgmt_mode) |=> !fault_n);

    // R11: management mode keeps the fault released
    p_mgmt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_mode |=> fault_n);

    // R8 / R9: the fault only falls after an unsuppressed event
    p_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past((|oc_evt) && !mgmt_mode));

endmodule

bind slot_pwr_status slot_pwr_status_chk #(.RAIL_W(RAIL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .oc_evt    (oc_evt),
    .on_en     (on_en),
    .auxen_en  (auxen_en),
    .mgmt_mode (mgmt_mode),
    .fault_n   (fault_n),
    .int_n     (int_n)
);

// File: tb/slot_pwr_status_test.sv
module slot_pwr_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] oc_evt = 5'b0;
    logic       main_good = 1'b0;
    logic       aux_good = 1'b0;
    logic       on_en = 1'b1;
    logic       auxen_en = 1'b1;
    logic       mgmt_mode = 1'b0;
    logic       fault_n;
    logic       int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_pend = 1'b0;

    // bench model of expected register contents
    logic [4:0] m_flags = 5'b0;
    logic       m_flt = 1'b0;

    always #2 clk = ~clk;

    slot_pwr_status uut (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .oc_evt(oc_evt),
        .main_good(main_good), .aux_good(aux_good), .on_en(on_en),
        .auxen_en(auxen_en), .mgmt_mode(mgmt_mode), .fault_n(fault_n),
        .int_n(int_n)
    );

    function automatic logic [7:0] model();
        return {m_flt, main_good, aux_good, m_flags};
    endfunction

    // monitor: compares read data one edge after each read strobe
    always @(posedge clk) mon_pend <= rd_en;

    always @(negedge clk) begin
        if (mon_pend && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: rd_data got %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        cmd_addr = a;
        rd_en    = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cmd_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        oc_evt = e;
        @(negedge clk);
        oc_evt = 5'b0;
    endtask

    task automatic pin(input logic got, input logic e, input string t);
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", t, got, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        pin(fault_n, 1'b1, "R1 fault_n");
        pin(int_n,   1'b1, "R1 int_n");
        rd(8'h05, 8'h00, "R1 reset read");

        // R7 live path states
        main_good = 1'b1; aux_good = 1'b1;
        rd(8'h05, model(), "R7 path states");

        // R3 / R8 / R12: 3.3 V event
        pulse(5'b00001);
        m_flags = 5'b00001; m_flt = 1'b1;
        pin(int_n,   1'b0, "R6 int asserted");
        pin(fault_n, 1'b0, "R8 fault asserted");
        rd(8'h05, model(), "R3 R12 status after event");

        // R4: zero writes and read-only bit writes do nothing
        wr(8'h05, 8'h00);
        rd(8'h05, model(), "R4 write zero");
        wr(8'h05, 8'hE0);
        rd(8'h05, model(), "R4 readonly write");

        // R2: other address
        wr(8'h06, 8'hFF);
        rd(8'h05, model(), "R2 foreign write ignored");
        rd(8'h06, 8'h00, "R2 foreign read");

        // R4 / R8: clear bit, fault stays
        wr(8'h05, 8'h01);
        m_flags = 5'b0;
        pin(int_n,   1'b1, "R6 int released");
        pin(fault_n, 1'b0, "R8 fault survives clear");
        rd(8'h05, model(), "R4 after clear");

        // R8: ON low releases
        on_en = 1'b0;
        @(negedge clk);
        m_flt = 1'b0;
        pin(fault_n, 1'b1, "R8 released by on_en");
        on_en = 1'b1;
        rd(8'h05, model(), "R12 after release");

        // R9: aux event
        pulse(5'b10000);
        m_flags = 5'b10000; m_flt = 1'b1;
        rd(8'h05, model(), "R3 R9 aux status");
        on_en = 1'b0;
        @(negedge clk);
        pin(fault_n, 1'b0, "R9 on_en does not release aux");
        on_en = 1'b1;
        auxen_en = 1'b0;
        @(negedge clk);
        m_flt = 1'b0;
        pin(fault_n, 1'b1, "R9 released by auxen_en");
        auxen_en = 1'b1;
        wr(8'h05, 8'h10);
        m_flags = 5'b0;

        // R10: both groups
        pulse(5'b10100);
        m_flags = 5'b10100; m_flt = 1'b1;
        rd(8'h05, model(), "R3 R10 both status");
        on_en = 1'b0;
        @(negedge clk);
        on_en = 1'b1;
        @(negedge clk);
        pin(fault_n, 1'b0, "R10 held after on_en only");
        auxen_en = 1'b0;
        @(negedge clk);
        m_flt = 1'b0;
        pin(fault_n, 1'b1, "R10 released after both");
        auxen_en = 1'b1;
        wr(8'h05, 8'h04);
        m_flags = 5'b10000;
        rd(8'h05, model(), "R4 partial clear");
        wr(8'h05, 8'h10);
        m_flags = 5'b0;

        // R5: set and clear same cycle
        oc_evt = 5'b00010;
        wr(8'h05, 8'h02);
        oc_evt = 5'b0;
        m_flags = 5'b00010; m_flt = 1'b1;
        rd(8'h05, model(), "R5 set wins");
        on_en = 1'b0;
        @(negedge clk);
        on_en = 1'b1;
        m_flt = 1'b0;
        wr(8'h05, 8'h02);
        m_flags = 5'b0;
        rd(8'h05, model(), "R5 later clear");

        // R11: management mode
        mgmt_mode = 1'b1;
        pulse(5'b01000);
        m_flags = 5'b01000;
        pin(fault_n, 1'b1, "R11 fault suppressed");
        pin(int_n,   1'b0, "R11 int still asserted");
        rd(8'h05, model(), "R11 status bit set, D7 clear");
        mgmt_mode = 1'b0;
        wr(8'h05, 8'h08);
        m_flags = 5'b0;
        pulse(5'b00001);
        m_flags = 5'b00001;
        pin(fault_n, 1'b0, "R11 fault before mode");
        mgmt_mode = 1'b1;
        @(negedge clk);
        pin(fault_n, 1'b1, "R11 mode releases fault");
        mgmt_mode = 1'b0;
        @(negedge clk);
        pin(fault_n, 1'b1, "R11 stays released");
        rd(8'h05, model(), "R12 D7 follows fault_n");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule